// File: doc/BRIEF.md
# Output Compare Waveform Generator

This block is one timer channel that produces a waveform on an output pin. A prescaler divides the clock into count ticks, and a period counter counts those ticks up to a programmed period. When the last tick of a period arrives, a compare event fires, the period counter starts again from zero, and the pin responds according to a 2-bit action setting. The action can hold the pin low, emit a high pulse from a low idle level, emit a low pulse from a high idle level, or invert the pin.

The pulse width is counted in undivided clock cycles, not in prescaled ticks. The pulse begins at the period boundary and runs on into the following period, so the spacing between compare events stays the same. If the pulse width is at least as long as a whole period, the pin stays at its active level. The counter enable clears every counter while it is low. While the enable is low, a preset level is also loaded into the toggle register, which gives the toggle action a known starting level. A one-clock event strobe marks each compare event so that it can be observed.

Top module: `ocWaveGen`

## Requirements
- R1: With action type 2'b00 the pin is low in every cycle, whatever the counter state and whatever compare events occur.
- R2: With action type 2'b01 the pin idles low. It is high for exactly pulseWidth clocks, starting in the cycle in which the event strobe is high.
- R3: With action type 2'b10 the pin idles high. It is low for exactly pulseWidth clocks, starting in the cycle in which the event strobe is high.
- R4: With action type 2'b11 the pin starts at the preset level and inverts once in each cycle in which the event strobe is high.
- R5: The pulse length is counted in clock cycles and does not depend on the prescaler. The pulse runs into the next period without delaying the next compare event.
- R6: The event strobe is high for one clock at the end of each period. Counting from the first enabled edge as edge 0, it rises after every edge k for which (k+1) is a multiple of (prescaleVal+1)*max(periodVal,1).
- R7: While cntEn is low, the prescaler, the period counter and the pulse are cleared. No event strobe occurs, and the toggle level is loaded from presetLevel.
- R8: If pulseWidth is greater than or equal to the period length in clocks, the pin stays at its active pulse level from the first event onward.
- R9: A pulseWidth of 0 produces no pulse, and the pin stays at its idle level in the pulse actions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Counter enable; low holds all counters in reset |
| periodVal | input | CNT_W | Period in prescaled ticks (0 is treated as 1) |
| prescaleVal | input | PRE_W | Prescaler; one tick every prescaleVal+1 clocks |
| actType | input | 2 | Compare action: 00 low, 01 high pulse, 10 low pulse, 11 toggle |
| pulseWidth | input | PW_W | Pulse width in undivided clocks |
| presetLevel | input | 1 | Level loaded into the toggle register while disabled |
| pinOut | output | 1 | Waveform pin level |
| eventStb | output | 1 | One-clock compare event strobe |

## Verification
A compare event is decided combinationally at the clock edge that ends a period. The strobe, the pulse counter and the toggle register are all loaded on that edge, so every result is visible one edge later. The pin is a combinational mux of that state and actType, so a change of action shows up at once. Taking the first enabled edge as edge 0, the bench samples at the falling edge after edge k and compares against closed-form expressions in k, the prescaler, the period and the width. A change of cntEn takes effect at the next rising edge, so the disable checks sample one falling edge after it.

// File: rtl/ocWaveGen_pkg.sv
package ocWaveGen_pkg;
  typedef enum logic [1:0] {
    ACT_LOW    = 2'b00,
    ACT_PULSEH = 2'b01,
    ACT_PULSEL = 2'b10,
    ACT_TOGGLE = 2'b11
  } actType_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cmpHit;  // last tick of the period, this edge
    logic clear;   // counters held in reset
  } ocStrobe_t;
endpackage

// File: rtl/ocCtrl.sv
module ocCtrl
  import ocWaveGen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [PRE_W-1:0] prescaleVal,
  output ocStrobe_t        strb
);
  localparam logic [CNT_W-1:0] PER_ONE = CNT_W'(1);

  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] perCnt;
  logic [CNT_W-1:0] perLast;
  logic             tick;
  logic             cmpHit;

  assign perLast = (periodVal == '0) ? '0 : periodVal - PER_ONE;
  assign tick    = cntEn && (preCnt >= prescaleVal);
  assign cmpHit  = tick && (perCnt >= perLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (!cntEn || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt <= '0;
    end else if (!cntEn) begin
      perCnt <= '0;
    end else if (tick) begin
      perCnt <= cmpHit ? '0 : perCnt + PER_ONE;
    end
  end

  always_comb begin
    strb        = '0;
    strb.cmpHit = cmpHit;
    strb.clear  = !cntEn;
  end
endmodule

// File: rtl/ocDatapath.sv
module ocDatapath
  import ocWaveGen_pkg::*;
#(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ocStrobe_t       strb,
  input  logic [1:0]      actType,
  input  logic [PW_W-1:0] pulseWidth,
  input  logic            presetLevel,
  output logic            pinOut,
  output logic            eventStb
);
  logic [PW_W-1:0] pulseCnt;
  logic            pulseAct;
  logic            toggleLvl;

  assign pulseAct = (pulseCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eventStb <= 1'b0;
    end else begin
      eventStb <= strb.cmpHit;
    end
  end

  // pulse counted in undivided clocks, reloaded at every event
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (strb.clear) begin
      pulseCnt <= '0;
    end else if (strb.cmpHit) begin
      pulseCnt <= pulseWidth;
    end else if (pulseAct) begin
      pulseCnt <= pulseCnt - PW_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleLvl <= 1'b0;
    end else if (strb.clear) begin
      toggleLvl <= presetLevel;
    end else if (strb.cmpHit) begin
      toggleLvl <= ~toggleLvl;
    end
  end

  always_comb begin
    unique case (actType_e'(actType))
      ACT_LOW:    pinOut = 1'b0;
      ACT_PULSEH: pinOut = pulseAct;
      ACT_PULSEL: pinOut = ~pulseAct;
      ACT_TOGGLE: pinOut = toggleLvl;
      default:    pinOut = 1'b0;
    endcase
  end
endmodule

// File: rtl/ocWaveGen.sv
module ocWaveGen
  import ocWaveGen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 8,
  parameter int PW_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntEn,
  input  logic [CNT_W-1:0] periodVal,
  input  logic [PRE_W-1:0] prescaleVal,
  input  logic [1:0]       actType,
  input  logic [PW_W-1:0]  pulseWidth,
  input  logic             presetLevel,
  output logic             pinOut,
  output logic             eventStb
);
  ocStrobe_t strb;

  ocCtrl #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cntEn      (cntEn),
    .periodVal  (periodVal),
    .prescaleVal(prescaleVal),
    .strb       (strb)
  );

  ocDatapath #(.PW_W(PW_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .actType    (actType),
    .pulseWidth (pulseWidth),
    .presetLevel(presetLevel),
    .pinOut     (pinOut),
    .eventStb   (eventStb)
  );
endmodule

// File: rtl/ocWaveGen_chk.sv
module ocWaveGen_chk #(
  parameter int PW_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            cntEn,
  input logic [1:0]      actType,
  input logic [PW_W-1:0] pulseWidth,
  input logic            pinOut,
  input logic            eventStb
);
  logic armed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  assert_forced_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    (actType == 2'b00) |-> !pinOut);

  assert_high_pulse_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    (armed && eventStb && actType == 2'b01 && $past(pulseWidth) != '0) |-> pinOut);

  assert_low_pulse_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (armed && eventStb && actType == 2'b10 && $past(pulseWidth) != '0) |-> !pinOut);

  assert_toggle_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (armed && eventStb && actType == 2'b11 && $past(actType) == 2'b11)
      |-> (pinOut != $past(pinOut)));

  assert_no_event_disabled_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> !eventStb);
endmodule

bind ocWaveGen ocWaveGen_chk #(.PW_W(PW_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cntEn     (cntEn),
  .actType   (actType),
  .pulseWidth(pulseWidth),
  .pinOut    (pinOut),
  .eventStb  (eventStb)
);

// File: tb/ocWaveGen_tb.sv
`timescale 1ns/1ps
module ocWaveGen_tb;
  localparam int CNT_W = 16;
  localparam int PRE_W = 8;
  localparam int PW_W  = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cntEn = 1'b0;
  logic [CNT_W-1:0] periodVal = '0;
  logic [PRE_W-1:0] prescaleVal = '0;
  logic [1:0]       actType = 2'b00;
  logic [PW_W-1:0]  pulseWidth = '0;
  logic             presetLevel = 1'b0;
  logic             pinOut;
  logic             eventStb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ocWaveGen #(.CNT_W(CNT_W), .PRE_W(PRE_W), .PW_W(PW_W)) u_dut (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .periodVal(periodVal),
    .prescaleVal(prescaleVal), .actType(actType), .pulseWidth(pulseWidth),
    .presetLevel(presetLevel), .pinOut(pinOut), .eventStb(eventStb)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference: pin and strobe after enabled edge k
  function automatic int expStb(int k, int n);
    return ((k + 1) % n == 0) ? 1 : 0;
  endfunction

  function automatic int expPin(int mode, int k, int n, int pw, int pre);
    int act;
    int flips;
    act   = ((k + 1) >= n && ((k + 1) % n) < pw) ? 1 : 0;
    flips = (k + 1) / n;
    case (mode)
      0: return 0;
      1: return act;
      2: return 1 - act;
      default: return pre ^ (flips % 2);
    endcase
  endfunction

  task automatic runCfg(input int mode, input int pre, input int per, input int pw, input int pset);
    int n;
    n = (pre + 1) * ((per == 0) ? 1 : per);
    @(negedge clk);
    cntEn       = 1'b0;
    actType     = 2'(mode);
    prescaleVal = PRE_W'(pre);
    periodVal   = CNT_W'(per);
    pulseWidth  = PW_W'(pw);
    presetLevel = pset[0];
    @(negedge clk);
    @(negedge clk);
    cntEn = 1'b1;
    for (int k = 0; k < 3 * n + 2; k++) begin
      @(negedge clk);
      chk("R6 strobe", int'(eventStb), expStb(k, n));
      case (mode)
        0: chk("R1 forced low", int'(pinOut), 0);
        1: chk((pw == 0) ? "R9 no pulse" : (pw >= n) ? "R8 continuous" : "R2 high pulse",
               int'(pinOut), expPin(mode, k, n, pw, pset));
        2: chk((pw == 0) ? "R9 no pulse" : (pw >= n) ? "R8 continuous" : "R3 low pulse",
               int'(pinOut), expPin(mode, k, n, pw, pset));
        default: chk("R4 toggle", int'(pinOut), expPin(mode, k, n, pw, pset));
      endcase
    end
  endtask

  initial begin
    int pwList[5];
    // reset state
    #1;
    chk("R1 reset pin", int'(pinOut), 0);
    chk("R6 reset strobe", int'(eventStb), 0);
    actType = 2'b10;
    #1;
    chk("R3 reset idle high", int'(pinOut), 1);
    actType = 2'b01;
    #1;
    chk("R2 reset idle low", int'(pinOut), 0);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // sweep of modes, prescaler, period and width; R5 covered by pre > 0 with pw in clocks
    for (int mode = 0; mode < 4; mode++)
      for (int pre = 0; pre < 3; pre++)
        for (int per = 0; per < 4; per++) begin
          int n;
          n = (pre + 1) * ((per == 0) ? 1 : per);
          pwList = '{0, 1, 3, n, n + 2};
          foreach (pwList[i])
            runCfg(mode, pre, per, pwList[i], (pre + per + i) % 2);
        end

    // R5: the pulse in clocks overlaps the next period, spacing unchanged
    runCfg(1, 2, 2, 4, 0);

    // R7: disable mid-pulse clears pulse and stops events
    runCfg(1, 1, 3, 5, 0);
    @(negedge clk);
    cntEn = 1'b0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk("R7 no strobe disabled", int'(eventStb), 0);
      chk("R7 pulse cleared", int'(pinOut), 0);
    end
    // R7: toggle level reloaded from preset while disabled
    actType = 2'b11;
    presetLevel = 1'b1;
    @(negedge clk);
    chk("R7 preset high", int'(pinOut), 1);
    presetLevel = 1'b0;
    @(negedge clk);
    chk("R7 preset low", int'(pinOut), 0);

    // R1: switching to forced low in mid-pulse drops the pin at once
    runCfg(1, 0, 4, 3, 0);
    @(negedge clk);
    pulseWidth = PW_W'(200);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk("R2 long pulse active", int'(pinOut), 1);
    actType = 2'b00;
    #1;
    chk("R1 immediate low", int'(pinOut), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule